// File: doc/BRIEF.md
# Calibrated One-Second Divider

This block turns a 32,768 Hz oscillator into a one-second tick. It can trim that tick by whole divider steps so that a slow or fast crystal keeps correct time over the long run. The chain has two stages. The first divides by 256. The second counts the outputs of the first stage to build the second. Correction happens only at the boundary between the two stages: one stage pulse is either dropped or stretched by half a stage period. Each adjusted minute has exactly one adjusted second.

A six-bit calibration field selects the trim. The five low bits give a magnitude N. The next bit gives the direction: 1 means the clock runs fast, 0 means it runs slow. The time-of-day counters outside the block pulse a minute strobe, which moves a 64-position minute index forward. The first 2N minutes of that cycle are adjusted. A 512 Hz square wave comes from the uncorrected first stage, so a tester can measure the raw crystal without seeing any trim. A stop input freezes the whole chain.

The widths are parameters: PRE_W for the first stage, POST_W for the second stage and CYCLE_W for the minute index. The values quoted below are the defaults.

Top module: `rtc_cal_divider`

## Requirements
- R1: While reset is low and in the first cycle after it is released, secTick is 0, testWave is 0 and minuteIdx is 0.
- R2: When a second is not adjusted, it lasts exactly 2^(PRE_W+POST_W) clock cycles (32,768 by default) between secTick pulses. This holds for every second when the magnitude bits calByte[4:0] are 0, whatever the other bits are. secTick is high for a single cycle.
- R3: An adjusted second with the direction bit calByte[5] = 1 is shorter by 2^PRE_W cycles (256), because one first-stage pulse is dropped.
- R4: An adjusted second with calByte[5] = 0 is longer by 2^(PRE_W-1) cycles (128), because one first-stage period is stretched by half.
- R5: A minute strobe makes a minute adjusted when the new minuteIdx value is less than 2N, where N = calByte[4:0]. Magnitude and direction are sampled with the strobe. In an adjusted minute, only the first whole second that starts at or after the strobe is adjusted, and the seconds that follow are nominal.
- R6: Each cycle with minuteStrobe high adds 1 to minuteIdx, and minuteIdx wraps from 63 to 0. Without a strobe, minuteIdx holds.
- R7: testWave is a square wave with a period of 64 cycles (512 Hz by default), high for 32 cycles and low for 32 cycles. It stays the same during adjusted seconds and whatever the calibration byte holds.
- R8: While stopBit is high, both stages hold their count, testWave does not change and no secTick occurs. Once stopBit is cleared, counting continues from where it stopped, so that second is longer by exactly the number of stopped cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock (nominally 32,768 Hz) |
| rstN | input | 1 | Asynchronous active-low reset |
| stopBit | input | 1 | Freezes the divider chain while high |
| calByte | input | 8 | Bits 4:0 are the trim magnitude, bit 5 is the direction (1 = fast), bits 7:6 are unused |
| minuteStrobe | input | 1 | One-cycle pulse from the time counters at each new minute |
| secTick | output | 1 | One-cycle pulse at the end of each second |
| testWave | output | 1 | 512 Hz uncorrected square wave |
| minuteIdx | output | 6 | Position in the 64-minute calibration cycle |

## Verification
The assertions check these rules on every cycle:
- the minute index steps by one on each strobe, wraps from 63 to 0 and otherwise holds;
- secTick is a single-cycle pulse;
- the chain is frozen while stopBit is high;
- at most one kind of adjustment is pending, and it changes only at a second boundary;
- every second length, counted over cycles that are not stopped, is one of the allowed lengths: nominal, 256 cycles shorter or 128 cycles longer.

Other behaviour can only be shown by the bench's scenarios:
- which length a particular second takes;
- that only the first second after a strobe is adjusted;
- the minute-index boundary at 2N;
- the exact 32/32 shape of the test wave during an adjusted second.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  // Adjustment request from control to datapath, valid for one whole second
  typedef struct packed {
    logic shortSec;  // drop one first-stage pulse
    logic longSec;   // stretch one first-stage period by half
  } calStrobe_t;

endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int CAL_W   = 5,
  parameter int CYCLE_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CAL_W-1:0]   calMag,
  input  logic               calPos,
  input  logic               minuteStrobe,
  input  logic               secTick,
  output calStrobe_t         adj,
  output logic [CYCLE_W-1:0] minuteIdx
);

  localparam int CMP_W = (CYCLE_W > CAL_W + 1) ? CYCLE_W : CAL_W + 1;

  logic [CYCLE_W-1:0] idxNext;
  logic [CMP_W-1:0]   idxExt;
  logic [CMP_W-1:0]   spanExt;
  logic               hitNext;
  logic               armed;
  logic               armedPos;
  logic               armNext;
  logic               posNext;

  // Minute k of the cycle is adjusted when k < 2 * magnitude
  always_comb begin
    idxNext = minuteIdx + CYCLE_W'(1);
    idxExt  = CMP_W'(idxNext);
    spanExt = CMP_W'({calMag, 1'b0});
    hitNext = idxExt < spanExt;
    armNext = minuteStrobe ? hitNext : armed;
    posNext = minuteStrobe ? calPos  : armedPos;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      minuteIdx    <= '0;
      armed        <= 1'b0;
      armedPos     <= 1'b0;
      adj.shortSec <= 1'b0;
      adj.longSec  <= 1'b0;
    end else begin
      if (minuteStrobe) minuteIdx <= idxNext;
      if (secTick) begin
        // a new second starts: hand the pending request to the datapath
        adj.shortSec <= armNext && posNext;
        adj.longSec  <= armNext && !posNext;
        armed        <= 1'b0;
      end else if (minuteStrobe) begin
        armed    <= hitNext;
        armedPos <= calPos;
      end
    end
  end

endmodule

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
#(
  parameter int PRE_W     = 8,
  parameter int POST_W    = 7,
  parameter int TEST_LOG2 = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stopBit,
  input  calStrobe_t adj,
  output logic       secTick,
  output logic       testWave
);

  localparam int STAGE_W = PRE_W + 1;
  localparam logic [STAGE_W-1:0] STAGE_LAST     = STAGE_W'(2 ** PRE_W - 1);
  localparam logic [STAGE_W-1:0] STAGE_LAST_EXT = STAGE_W'(2 ** PRE_W + 2 ** (PRE_W - 1) - 1);
  localparam logic [POST_W-1:0]  SEC_LAST       = '1;
  localparam logic [POST_W-1:0]  SEC_LAST_SHORT = SEC_LAST - POST_W'(1);

  logic [STAGE_W-1:0] stageCnt;
  logic [POST_W-1:0]  secCnt;
  logic               stretchNow;
  logic               stageTerm;
  logic               secTerm;

  always_comb begin
    // the last first-stage period of a lengthened second runs 1.5 periods
    stretchNow = adj.longSec && (secCnt == SEC_LAST);
    stageTerm  = stageCnt == (stretchNow ? STAGE_LAST_EXT : STAGE_LAST);
    // a shortened second ends one stage pulse early
    secTerm    = stageTerm && (secCnt == (adj.shortSec ? SEC_LAST_SHORT : SEC_LAST));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageCnt <= '0;
      secCnt   <= '0;
      secTick  <= 1'b0;
    end else begin
      secTick <= !stopBit && secTerm;
      if (!stopBit) begin
        stageCnt <= stageTerm ? '0 : stageCnt + STAGE_W'(1);
        if (stageTerm) secCnt <= secTerm ? '0 : secCnt + POST_W'(1);
      end
    end
  end

  // The extended period is a whole number of test periods, so this tap is untouched
  assign testWave = stageCnt[TEST_LOG2-1];

endmodule

// File: rtl/rtc_cal_divider.sv
module rtc_cal_divider
  import rtc_cal_pkg::*;
#(
  parameter int PRE_W     = 8,
  parameter int POST_W    = 7,
  parameter int TEST_LOG2 = 6,
  parameter int CAL_W     = 5,
  parameter int CYCLE_W   = 6,
  parameter int CTRL_W    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stopBit,
  input  logic [CTRL_W-1:0]  calByte,
  input  logic               minuteStrobe,
  output logic               secTick,
  output logic               testWave,
  output logic [CYCLE_W-1:0] minuteIdx
);

  calStrobe_t calStrobes;

  rtc_cal_ctrl #(
    .CAL_W  (CAL_W),
    .CYCLE_W(CYCLE_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .calMag      (calByte[CAL_W-1:0]),
    .calPos      (calByte[CAL_W]),
    .minuteStrobe(minuteStrobe),
    .secTick     (secTick),
    .adj         (calStrobes),
    .minuteIdx   (minuteIdx)
  );

  rtc_cal_datapath #(
    .PRE_W    (PRE_W),
    .POST_W   (POST_W),
    .TEST_LOG2(TEST_LOG2)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stopBit (stopBit),
    .adj     (calStrobes),
    .secTick (secTick),
    .testWave(testWave)
  );

endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker
  import rtc_cal_pkg::*;
#(
  parameter int PRE_W   = 8,
  parameter int POST_W  = 7,
  parameter int CYCLE_W = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               stopBit,
  input logic               minuteStrobe,
  input logic               secTick,
  input logic               testWave,
  input logic [CYCLE_W-1:0] minuteIdx,
  input calStrobe_t         adj
);

  localparam int NOM_LEN   = 2 ** (PRE_W + POST_W);
  localparam int SHORT_LEN = NOM_LEN - 2 ** PRE_W;
  localparam int LONG_LEN  = NOM_LEN + 2 ** (PRE_W - 1);

  // counts running (not stopped) cycles since the last second boundary
  int lenCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lenCnt <= 0;
    else if (secTick) lenCnt <= stopBit ? 0 : 1;
    else if (!stopBit) lenCnt <= lenCnt + 1;
  end

  p_idx_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    minuteStrobe |=> minuteIdx == CYCLE_W'($past(minuteIdx) + CYCLE_W'(1)));

  p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !minuteStrobe |=> $stable(minuteIdx));

  p_stop_freeze_r8: assert property (@(posedge clk) disable iff (!rstN)
    stopBit |=> ($stable(testWave) && !secTick));

  p_tick_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    secTick |=> !secTick);

  // R3 and R4: only the three legal second lengths ever occur
  p_sec_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    secTick |-> (lenCnt == NOM_LEN || lenCnt == SHORT_LEN || lenCnt == LONG_LEN));

  p_one_adj_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({adj.shortSec, adj.longSec}));

  p_adj_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !secTick |=> $stable(adj));

endmodule

bind rtc_cal_divider rtc_cal_checker #(
  .PRE_W  (PRE_W),
  .POST_W (POST_W),
  .CYCLE_W(CYCLE_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .stopBit     (stopBit),
  .minuteStrobe(minuteStrobe),
  .secTick     (secTick),
  .testWave    (testWave),
  .minuteIdx   (minuteIdx),
  .adj         (calStrobes)
);

// File: tb/rtc_cal_divider_tb.sv
`timescale 1ns/1ps
module rtc_cal_divider_tb;

  localparam int PRE_W     = 8;
  localparam int POST_W    = 4;
  localparam int TEST_LOG2 = 6;
  localparam int NOM       = 2 ** (PRE_W + POST_W);
  localparam int SHORT     = NOM - 2 ** PRE_W;
  localparam int LONG      = NOM + 2 ** (PRE_W - 1);
  localparam int HALF_TEST = 2 ** (TEST_LOG2 - 1);

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       stopBit = 1'b0;
  logic [7:0] calByte = 8'h00;
  logic       minuteStrobe = 1'b0;
  logic       secTick;
  logic       testWave;
  logic [5:0] minuteIdx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lastTickCyc = 0;
  int lastLen = 0;
  int tickNum = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_cal_divider #(
    .PRE_W(PRE_W), .POST_W(POST_W), .TEST_LOG2(TEST_LOG2),
    .CAL_W(5), .CYCLE_W(6), .CTRL_W(8)
  ) u_dut (
    .clk(clk), .rstN(rstN), .stopBit(stopBit), .calByte(calByte),
    .minuteStrobe(minuteStrobe), .secTick(secTick), .testWave(testWave),
    .minuteIdx(minuteIdx)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN && secTick) begin
      lastLen     = cyc - lastTickCyc;
      lastTickCyc = cyc;
      tickNum     = tickNum + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitTick(output int len);
    int n = tickNum;
    wait (tickNum != n);
    len = lastLen;
  endtask

  task automatic pulseStrobe();
    @(negedge clk) minuteStrobe = 1'b1;
    @(negedge clk) minuteStrobe = 1'b0;
  endtask

  task automatic measureHalf(output int n);
    logic v = testWave;
    n = 0;
    while (testWave == v && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic checkWave(input string req);
    int n;
    measureHalf(n);          // align to an edge
    measureHalf(n);
    check(n == HALF_TEST, req, n, HALF_TEST);
    measureHalf(n);
    check(n == HALF_TEST, req, n, HALF_TEST);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check(secTick == 1'b0 && testWave == 1'b0, "R1 outputs in reset", {secTick, testWave}, 0);
    check(minuteIdx == 6'd0, "R1 index in reset", minuteIdx, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(secTick == 1'b0 && testWave == 1'b0 && minuteIdx == 6'd0, "R1 after release",
          {secTick, testWave, minuteIdx}, 0);
  endtask

  task automatic testNominal();
    int len;
    calByte = 8'hE0;         // magnitude 0 with direction and unused bits set
    pulseStrobe();
    waitTick(len);
    waitTick(len);
    check(len == NOM, "R2 nominal second", len, NOM);
    waitTick(len);
    check(len == NOM, "R2 nominal second repeat", len, NOM);
    checkWave("R7 test wave nominal");
  endtask

  task automatic testShort();
    int len;
    waitTick(len);
    calByte = 8'h21;         // fast, magnitude 1
    pulseStrobe();           // index becomes 2? no: from 1 to 2
    calByte = 8'h00;         // sampled value must be kept
    waitTick(len);
    waitTick(len);
    check(len == NOM, "R5 index 2 not below 2 for magnitude 1", len, NOM);
    calByte = 8'h22;         // fast, magnitude 2
    pulseStrobe();           // index 3 < 4
    calByte = 8'h00;
    waitTick(len);
    check(len == NOM, "R5 second in progress untouched", len, NOM);
    checkWave("R7 test wave during shortened second");
    waitTick(len);
    check(len == SHORT, "R3 shortened second", len, SHORT);
    waitTick(len);
    check(len == NOM, "R5 only one second adjusted", len, NOM);
  endtask

  task automatic testLong();
    int len;
    waitTick(len);
    calByte = 8'h03;         // slow, magnitude 3
    pulseStrobe();           // index 4 < 6
    waitTick(len);
    waitTick(len);
    check(len == LONG, "R4 lengthened second", len, LONG);
    waitTick(len);
    check(len == NOM, "R4 next second nominal", len, NOM);
  endtask

  task automatic testWrap();
    int len;
    waitTick(len);
    calByte = 8'h02;         // slow, magnitude 2
    for (int i = 0; i < 59; i++) pulseStrobe();
    @(negedge clk);
    check(minuteIdx == 6'd63, "R6 index reaches 63", minuteIdx, 63);
    repeat (20) @(negedge clk);
    check(minuteIdx == 6'd63, "R6 index holds without strobe", minuteIdx, 63);
    pulseStrobe();
    check(minuteIdx == 6'd0, "R6 index wraps to 0", minuteIdx, 0);
    waitTick(len);
    waitTick(len);
    check(len == LONG, "R5 minute 0 adjusted after wrap", len, LONG);
  endtask

  task automatic testStop();
    int len;
    int bad = 0;
    logic w;
    calByte = 8'h00;
    waitTick(len);
    repeat (200) @(negedge clk);
    stopBit = 1'b1;
    @(negedge clk);
    w = testWave;
    for (int i = 0; i < 499; i++) begin
      @(negedge clk);
      if (secTick || testWave != w) bad++;
    end
    stopBit = 1'b0;
    check(bad == 0, "R8 frozen while stopped", bad, 0);
    waitTick(len);
    check(len == NOM + 500, "R8 resume from held count", len, NOM + 500);
  endtask

  initial begin
    testReset();
    testNominal();
    testShort();
    testLong();
    testWrap();
    testStop();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule